// File: doc/BRIEF.md
# Digit-Serial Binary Field Arithmetic Unit

This unit performs arithmetic in GF(2^N) with polynomial basis. It adds, squares or multiplies two N-bit field elements and writes the chosen result into an N-bit result register. The field polynomial is fixed at build time. By default it is x^163 + x^7 + x^6 + x^3 + 1 with N = 163 and a digit width M = 4. The parameter `POLY_LOW` holds every term of the polynomial below x^N.

Addition and squaring finish in one clock edge. Multiplication takes the second operand M bits at a time, starting at the most significant digit. Each digit cycle shifts the running product left by M bits and adds the partial product of operand A times the digit. The M bits that overflow past position N-1 are then folded straight back into the low N bits. No register is ever wider than N bits plus the padded digit register.

The controller has two states. In `ST_IDLE` the unit accepts `start`. `IDLE->IDLE` is taken on add, square, the reserved opcode, or no request. `IDLE->MULT` is taken on a multiply and loads the operands. In `ST_MULT` the unit stays (`MULT->MULT`) while digits remain and returns (`MULT->IDLE`) on the last digit, writing the product.

Top module: `gf2m_arith_unit`

## Requirements
- R1: After reset, `result` is zero and both `busy` and `done` are low.
- R2: Opcode 2'b00 (add) accepted in idle writes op_a XOR op_b to `result` at the accepting edge. `done` is high for the following cycle and `busy` never rises.
- R3: Opcode 2'b01 (square) accepted in idle writes op_a squared modulo the field polynomial at the accepting edge, with the same `done` timing as R2 and `busy` low.
- R4: Opcode 2'b10 (multiply) yields op_a times op_b modulo the field polynomial. This holds when either operand is zero or one and when both are all ones.
- R5: For a multiply, `busy` is high for exactly ceil(N/M) cycles, starting right after the accepting edge. `done` and the product appear at the ceil(N/M)+1-th edge, counting the accepting edge as the first.
- R6: When N is not a multiple of M, op_b is zero-padded above bit N-1, and products remain exact (checked with N=8, M=3, polynomial low terms 8'h1B).
- R7: `done` is never high together with `busy`, and `result` changes only at an edge that raises `done`. With no new request, `done` falls after one cycle.
- R8: A `start` seen while `busy` is high is ignored. The running product completes unchanged, with exactly one `done` pulse.
- R9: Opcode 2'b11 is reserved. Accepting it leaves `result` unchanged and raises neither `done` nor `busy`.
- R10: A request applied in the cycle in which `done` is high is accepted at the next edge, giving back-to-back operations with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request valid; sampled only in idle |
| opcode | input | 2 | 00 add, 01 square, 10 multiply, 11 reserved |
| op_a | input | N | First operand |
| op_b | input | N | Second operand (digit source for multiply) |
| busy | output | 1 | High while a multiply is in its digit cycles |
| done | output | 1 | One-cycle pulse when `result` was written |
| result | output | N | Result register |

## Verification
Two events can share a cycle. One is the `done` pulse that ends one operation, which can coincide with the acceptance of the next request. The other is a running multiply that receives a fresh `start`. The bench provokes the first case by applying a new add or multiply in exactly the cycle in which `done` is seen high. It then judges that the earlier result was reported and that the new result appears with its normal latency. For the second case it holds `start` high with an add request during the first digit cycles. It requires a single `done` pulse, carrying the product, at the standard multiply latency.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SQR = 2'b01,
        OP_MUL = 2'b10,
        OP_RSV = 2'b11
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MULT = 1'b1
    } state_e;

    typedef enum logic [1:0] {
        SEL_HOLD = 2'b00,
        SEL_ADD  = 2'b01,
        SEL_SQR  = 2'b10,
        SEL_MUL  = 2'b11
    } rsel_e;

endpackage

// File: rtl/gf2m_fold.sv
// Folds an (N+M)-bit value whose top M bits overflow back into N bits:
// low part, first fold of the overflow, second fold of what the first
// fold pushes past bit N-1.
module gf2m_fold #(
    parameter int          N        = 163,
    parameter int          M        = 4,
    parameter logic [N-1:0] POLY_LOW = N'(8'hC9)
) (
    input  logic [N+M-1:0] wide,
    output logic [N-1:0]   folded
);
    localparam int WW = N + M;

    logic [M-1:0]  ovf_1;
    logic [M-1:0]  ovf_2;
    logic [WW-1:0] fold_1;
    logic [WW-1:0] fold_2;
    logic [WW-1:0] poly_ext;

    assign poly_ext = {{M{1'b0}}, POLY_LOW};
    assign ovf_1    = wide[WW-1:N];

    always_comb begin
        fold_1 = '0;
        for (int j = 0; j < M; j++) begin
            if (ovf_1[j]) begin
                fold_1 = fold_1 ^ (poly_ext << j);
            end
        end
    end

    assign ovf_2 = fold_1[WW-1:N];

    always_comb begin
        fold_2 = '0;
        for (int j = 0; j < M; j++) begin
            if (ovf_2[j]) begin
                fold_2 = fold_2 ^ (poly_ext << j);
            end
        end
    end

    assign folded = wide[N-1:0] ^ fold_1[N-1:0] ^ fold_2[N-1:0];

endmodule

// File: rtl/gf2m_digit_mac.sv
// One digit step: shift the running value left by M, add A times the digit,
// fold the overflow back below x^N.
module gf2m_digit_mac #(
    parameter int           N        = 163,
    parameter int           M        = 4,
    parameter logic [N-1:0] POLY_LOW = N'(8'hC9)
) (
    input  logic [N-1:0] acc,
    input  logic [N-1:0] mult_a,
    input  logic [M-1:0] digit,
    output logic [N-1:0] acc_next
);
    localparam int WW = N + M;

    logic [WW-1:0] rows [M];
    logic [WW-1:0] pprod;
    logic [WW-1:0] merged;

    for (genvar g = 0; g < M; g++) begin : g_row
        assign rows[g] = digit[g] ? ({{M{1'b0}}, mult_a} << g) : '0;
    end

    always_comb begin
        pprod = '0;
        for (int j = 0; j < M; j++) begin
            pprod = pprod ^ rows[j];
        end
    end

    assign merged = {acc, {M{1'b0}}} ^ pprod;

    gf2m_fold #(
        .N        (N),
        .M        (M),
        .POLY_LOW (POLY_LOW)
    ) u_fold (
        .wide   (merged),
        .folded (acc_next)
    );

endmodule

// File: rtl/gf2m_square.sv
// Single-cycle squarer: spread bits with zero gaps, then reduce from the top.
module gf2m_square #(
    parameter int           N        = 163,
    parameter logic [N-1:0] POLY_LOW = N'(8'hC9)
) (
    input  logic [N-1:0] sq_in,
    output logic [N-1:0] sq_out
);
    localparam int SW = 2 * N - 1;

    logic [SW-1:0] poly_ext;
    logic [SW-1:0] work;

    assign poly_ext = {{(N-1){1'b0}}, POLY_LOW};

    always_comb begin
        work = '0;
        for (int i = 0; i < N; i++) begin
            work[2*i] = sq_in[i];
        end
        for (int i = SW - 1; i >= N; i--) begin
            if (work[i]) begin
                work = work ^ (poly_ext << (i - N));
            end
        end
    end

    assign sq_out = work[N-1:0];

endmodule

// File: rtl/gf2m_arith_unit.sv
module gf2m_arith_unit
    import gf2m_pkg::*;
#(
    parameter int           N        = 163,
    parameter int           M        = 4,
    parameter logic [N-1:0] POLY_LOW = N'(8'hC9)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   opcode,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] result
);
    localparam int DIGITS = (N + M - 1) / M;
    localparam int BW     = DIGITS * M;
    localparam int CW     = $clog2(DIGITS + 1);

    state_e        state_q, state_d;
    rsel_e         sel;
    op_e           op_in;
    logic          load_mul;
    logic          step;
    logic          last_digit;

    logic [N-1:0]  mul_a_q;
    logic [BW-1:0] b_sh_q;
    logic [N-1:0]  acc_q;
    logic [CW-1:0] dcnt_q;
    logic [N-1:0]  result_q;
    logic          done_q;
    logic [N-1:0]  res_d;

    logic [M-1:0]  digit;
    logic [N-1:0]  mac_out;
    logic [N-1:0]  sq_out;

    assign op_in      = op_e'(opcode);
    assign digit      = b_sh_q[BW-1 -: M];
    assign last_digit = (dcnt_q == CW'(DIGITS - 1));

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state and controls ----------------
    always_comb begin
        state_d  = state_q;
        sel      = SEL_HOLD;
        load_mul = 1'b0;
        step     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    unique case (op_in)
                        OP_ADD: sel = SEL_ADD;
                        OP_SQR: sel = SEL_SQR;
                        OP_MUL: begin
                            load_mul = 1'b1;
                            state_d  = ST_MULT;
                        end
                        OP_RSV: sel = SEL_HOLD;
                    endcase
                end
            end
            ST_MULT: begin
                step = 1'b1;
                if (last_digit) begin
                    sel     = SEL_MUL;
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // ---------------- multiply datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mul_a_q <= '0;
            b_sh_q  <= '0;
            acc_q   <= '0;
            dcnt_q  <= '0;
        end else if (load_mul) begin
            mul_a_q <= op_a;
            b_sh_q  <= BW'(op_b);
            acc_q   <= '0;
            dcnt_q  <= '0;
        end else if (step) begin
            acc_q   <= mac_out;
            b_sh_q  <= b_sh_q << M;
            dcnt_q  <= dcnt_q + CW'(1);
        end
    end

    gf2m_digit_mac #(
        .N        (N),
        .M        (M),
        .POLY_LOW (POLY_LOW)
    ) u_mac (
        .acc      (acc_q),
        .mult_a   (mul_a_q),
        .digit    (digit),
        .acc_next (mac_out)
    );

    gf2m_square #(
        .N        (N),
        .POLY_LOW (POLY_LOW)
    ) u_sqr (
        .sq_in  (op_a),
        .sq_out (sq_out)
    );

    // ---------------- result select ----------------
    always_comb begin
        unique case (sel)
            SEL_HOLD: res_d = result_q;
            SEL_ADD:  res_d = op_a ^ op_b;
            SEL_SQR:  res_d = sq_out;
            SEL_MUL:  res_d = mac_out;
        endcase
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            result_q <= res_d;
            done_q   <= (sel != SEL_HOLD);
        end
    end

    assign result = result_q;
    assign done   = done_q;
    assign busy   = (state_q == ST_MULT);

endmodule

// File: rtl/gf2m_arith_unit_chk.sv
module gf2m_arith_unit_chk #(
    parameter int N = 163,
    parameter int M = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   opcode,
    input logic         busy,
    input logic         done,
    input logic [N-1:0] result
);
    localparam int DIGITS = (N + M - 1) / M;

    int busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= 0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1;
        end else begin
            busy_cnt <= 0;
        end
    end

    // R5
    mul_busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && opcode == 2'b10) |=> busy);

    // R5
    mul_busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == DIGITS && done));

    // R2
    short_op_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (opcode == 2'b00 || opcode == 2'b01)) |=> (!busy && done));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R9
    reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && opcode == 2'b11) |=> (!done && !busy && $stable(result)));

endmodule

bind gf2m_arith_unit gf2m_arith_unit_chk #(
    .N (N),
    .M (M)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .opcode (opcode),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/gf2m_arith_unit_bench.sv
module gf2m_arith_unit_bench;
    localparam int BN = 163;
    localparam int BM = 4;
    localparam int BD = (BN + BM - 1) / BM;
    localparam int SN = 8;
    localparam int SM = 3;
    localparam int SD = (SN + SM - 1) / SM;
    localparam logic [BN-1:0] BPOLY = BN'(8'hC9);
    localparam logic [SN-1:0] SPOLY = 8'h1B;
    localparam logic [BN-1:0] P1 = BN'({6{32'hA5C396E1}});
    localparam logic [BN-1:0] P2 = BN'({6{32'h3B7E0D52}});

    logic clk = 1'b0;
    always #5 clk = ~clk;
    logic rst_n;

    logic          b_start;
    logic [1:0]    b_op;
    logic [BN-1:0] b_a, b_b;
    logic          b_busy, b_done;
    logic [BN-1:0] b_res;

    logic          s_start;
    logic [1:0]    s_op;
    logic [SN-1:0] s_a, s_b;
    logic          s_busy, s_done;
    logic [SN-1:0] s_res;

    int n_tests = 0;
    int n_fail  = 0;

    gf2m_arith_unit u_gf2m_arith_unit (
        .clk(clk), .rst_n(rst_n), .start(b_start), .opcode(b_op),
        .op_a(b_a), .op_b(b_b), .busy(b_busy), .done(b_done), .result(b_res)
    );

    gf2m_arith_unit #(.N(SN), .M(SM), .POLY_LOW(SPOLY)) u_small (
        .clk(clk), .rst_n(rst_n), .start(s_start), .opcode(s_op),
        .op_a(s_a), .op_b(s_b), .busy(s_busy), .done(s_done), .result(s_res)
    );

    function automatic logic [BN-1:0] ref_mul(input logic [BN-1:0] a, input logic [BN-1:0] b,
                                              input int n, input logic [BN-1:0] plow);
        logic [BN-1:0] r    = '0;
        logic [BN-1:0] mask = '0;
        logic          top;
        for (int k = 0; k < n; k++) mask[k] = 1'b1;
        for (int i = n - 1; i >= 0; i--) begin
            top = r[n-1];
            r   = (r << 1) & mask;
            if (top)  r = r ^ plow;
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [BN-1:0] act, input logic [BN-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // entered and left at a negedge; returns at the negedge where done is seen
    task automatic run_big(input logic [1:0] op, input logic [BN-1:0] a, input logic [BN-1:0] b,
                           output logic [BN-1:0] res, output int lat);
        b_op = op; b_a = a; b_b = b; b_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        b_start = 1'b0;
        chk(op == 2'b10 ? "R5 busy after accept" : "R2 busy stays low",
            BN'(b_busy), BN'(op == 2'b10));
        lat = 1;
        while (!b_done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        res = b_res;
    endtask

    task automatic run_small(input logic [1:0] op, input logic [SN-1:0] a, input logic [SN-1:0] b,
                             output logic [SN-1:0] res, output int lat);
        s_op = op; s_a = a; s_b = b; s_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s_start = 1'b0;
        lat = 1;
        while (!s_done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        res = s_res;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [BN-1:0] vals [5];
        logic [BN-1:0] r, keep;
        logic [SN-1:0] sr, sb;
        int lat, pulses;

        vals[0] = '0; vals[1] = BN'(1); vals[2] = '1; vals[3] = P1; vals[4] = P2;
        rst_n = 1'b0;
        b_start = 1'b0; b_op = 2'b00; b_a = '0; b_b = '0;
        s_start = 1'b0; s_op = 2'b00; s_a = '0; s_b = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 result", b_res, '0);
        chk("R1 busy",   BN'(b_busy), '0);
        chk("R1 done",   BN'(b_done), '0);
        chk("R1 small result", BN'(s_res), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R2 R3 on the default field, corner operands
        for (int x = 0; x < 5; x++) begin
            for (int y = 0; y < 5; y++) begin
                run_big(2'b10, vals[x], vals[y], r, lat);
                chk("R4 product", r, ref_mul(vals[x], vals[y], BN, BPOLY));
                chk("R5 multiply latency", BN'(lat), BN'(BD + 1));
                @(negedge clk);
                // R7 done falls and result holds without a request
                chk("R7 done one cycle", BN'(b_done), '0);
                chk("R7 result held", b_res, r);
                run_big(2'b00, vals[x], vals[y], r, lat);
                chk("R2 sum", r, vals[x] ^ vals[y]);
                chk("R2 latency", BN'(lat), BN'(1));
            end
            run_big(2'b01, vals[x], '0, r, lat);
            chk("R3 square", r, ref_mul(vals[x], vals[x], BN, BPOLY));
            chk("R3 latency", BN'(lat), BN'(1));
        end

        // R6 near-exhaustive sweep on N=8, M=3
        for (int a = 0; a < 256; a++) begin
            for (int j = 0; j < 8; j++) begin
                sb = SN'(a * 29 + j * 37);
                run_small(2'b10, SN'(a), sb, sr, lat);
                chk("R6 small product", BN'(sr), ref_mul(BN'(a), BN'(sb), SN, BN'(SPOLY)));
                if (j == 0) chk("R6 small latency", BN'(lat), BN'(SD + 1));
            end
            run_small(2'b01, SN'(a), '0, sr, lat);
            chk("R3 small square", BN'(sr), ref_mul(BN'(a), BN'(a), SN, BN'(SPOLY)));
        end
        run_small(2'b10, '1, '1, sr, lat);
        chk("R6 small all ones", BN'(sr), ref_mul(BN'(8'hFF), BN'(8'hFF), SN, BN'(SPOLY)));

        // R8 start while busy is ignored
        @(negedge clk);
        b_op = 2'b10; b_a = P1; b_b = P2; b_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        b_op = 2'b00; b_a = '1; b_b = P1;
        pulses = 0;
        lat = 0;
        for (int c = 0; c < BD + 4; c++) begin
            if (c == 4) b_start = 1'b0;
            if (b_done) begin
                pulses++;
                lat = c + 1;
            end
            @(negedge clk);
        end
        chk("R8 single done", BN'(pulses), BN'(1));
        chk("R8 latency", BN'(lat), BN'(BD + 1));
        chk("R8 product kept", b_res, ref_mul(P1, P2, BN, BPOLY));

        // R9 reserved opcode ignored
        keep = b_res;
        b_op = 2'b11; b_a = '1; b_b = '1; b_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        b_start = 1'b0;
        for (int c = 0; c < 3; c++) begin
            chk("R9 no done", BN'(b_done), '0);
            chk("R9 no busy", BN'(b_busy), '0);
            chk("R9 result unchanged", b_res, keep);
            @(negedge clk);
        end

        // R10 back-to-back: next request in the cycle done is high
        run_big(2'b10, P2, P1, r, lat);
        chk("R10 first product", r, ref_mul(P2, P1, BN, BPOLY));
        chk("R10 done present", BN'(b_done), BN'(1));
        run_big(2'b00, P1, vals[2], r, lat);
        chk("R10 add after multiply", r, P1 ^ vals[2]);
        chk("R10 add latency", BN'(lat), BN'(1));
        run_big(2'b10, vals[2], P2, r, lat);
        chk("R10 multiply after add", r, ref_mul(vals[2], P2, BN, BPOLY));
        chk("R10 multiply latency", BN'(lat), BN'(BD + 1));
        run_big(2'b01, P2, '0, r, lat);
        chk("R10 square after multiply", r, ref_mul(P2, P2, BN, BPOLY));

        @(negedge clk);
        report();
        $finish;
    end

endmodule